// File: doc/BRIEF.md
# Self-Recovering Galois LFSR Generator

This block is an N-bit Galois linear feedback shift register that shifts right by one place on every enabled clock cycle. When the bit leaving position 0 meets the tap condition, a feedback mask is XORed into the shifted word. It produces a parallel state word and a serial pseudo-random bit taken from state bit 0. A parameter selects one of two tap polarities. In the plain polarity, the mask is applied when the departing bit is 1. In the flipped polarity, it is applied when the departing bit is 0.

Each polarity has exactly one state that maps onto itself, so a register holding that state would never leave it. In the plain polarity this state is all zeros. In the flipped polarity it is a word derived from the mask at elaboration. The block recognises this state and, on the next enabled step, replaces it with the start-up seed. A one-cycle flag marks that step.

The start-up seed is a word with a single 1. Reset clears every storage flop, but one chosen flop is stored in inverted form, so the state read out after reset holds that single 1. A load port writes an arbitrary word into the register. It is used to start the sequence from any point or to place the register in the stuck state on purpose.

Top module: `galois_lfsr_gen`

## Requirements
- R1: A synchronous reset sets `state_o` to a word whose only 1 is at position SEED_BIT (0x01 for the default), and `recov_o` is 0 in the cycle after reset.
- R2: With the plain polarity (FLIP_POL=0), an enabled step from state s gives `(s >> 1) ^ (s[0] ? MASK : 0)`.
- R3: With the flipped polarity (FLIP_POL=1), an enabled step from state s gives `(s >> 1) ^ (s[0] ? 0 : MASK)`.
- R4: While `en_i` and `ld_i` are both 0, `state_o` keeps its value.
- R5: `bit_o` always equals bit 0 of `state_o`.
- R6: With the primitive default mask 0xB8 at N=8, the state returns to the seed after exactly 255 enabled steps in either polarity.
- R7: With the default mask, the serial output never shows more than N-1 (7) consecutive zeros.
- R8: The stuck state is all zeros in the plain polarity. In the flipped polarity it has bit 0 clear and bit k+1 equal to bit k XOR MASK[k] (0xD0 for 0xB8). An enabled step from the stuck state gives the seed one cycle later.
- R9: `recov_o` is 1 exactly in cycles where `en_i` is 1, `ld_i` is 0 and `state_o` is the stuck state. It is never high in two cycles in a row.
- R10: When `ld_i` is 1, the next `state_o` is `ld_val_i`, whatever `en_i` is and even from the stuck state. In that cycle `recov_o` is 0.
- R11: Reset takes priority over load and enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the register by one step |
| ld_i | input | 1 | Write `ld_val_i` into the state |
| ld_val_i | input | N | Word to load |
| state_o | output | N | Current state word |
| bit_o | output | 1 | Serial output, state bit 0 |
| recov_o | output | 1 | High when the step taken this cycle is the forced escape |

## Verification
Two functions can fall in the same cycle: the forced escape, which applies when the register sits in its stuck state with enable high, and a load. The bench places each instance in its stuck state with a load while enable is held low, then raises load and enable together. The flag must stay low, and the next state must be the loaded word rather than the seed. A full sweep loads all 256 words, steps once, and compares each result with either the arithmetic step or the seed, so the escape is judged against every ordinary transition.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

   localparam int unsigned LFSR_MAX_W = 64;

   // Fixed point of the step map for the chosen tap polarity.
   function automatic logic [LFSR_MAX_W-1:0] lockup_word(
      input logic [LFSR_MAX_W-1:0] mask,
      input int unsigned           n,
      input bit                    flip);
      logic [LFSR_MAX_W-1:0] x;
      x = '0;
      if (flip) begin
         for (int unsigned k = 0; k + 1 < n; k++) begin
            x[k+1] = x[k] ^ mask[k];
         end
      end
      return x;
   endfunction

   // One step of the map, used only for elaboration checks.
   function automatic logic [LFSR_MAX_W-1:0] step_word(
      input logic [LFSR_MAX_W-1:0] s,
      input logic [LFSR_MAX_W-1:0] mask,
      input int unsigned           n,
      input bit                    flip);
      logic [LFSR_MAX_W-1:0] t;
      logic [LFSR_MAX_W-1:0] keep;
      keep = (n >= LFSR_MAX_W) ? '1 : ((64'd1 << n) - 64'd1);
      t    = (s & keep) >> 1;
      if (s[0] ^ flip) t = t ^ mask;
      return t & keep;
   endfunction

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step #(
   parameter int unsigned N        = 8,
   parameter logic [N-1:0] MASK    = 8'hB8,
   parameter bit           FLIP_POL = 1'b0
) (
   input  logic [N-1:0] cur_i,
   output logic [N-1:0] nxt_o
);

   logic tap;

   generate
      if (FLIP_POL) begin : g_tap_on_zero
         assign tap = ~cur_i[0];
      end else begin : g_tap_on_one
         assign tap = cur_i[0];
      end
   endgenerate

   assign nxt_o = {1'b0, cur_i[N-1:1]} ^ (tap ? MASK : {N{1'b0}});

endmodule

// File: rtl/lfsr_lockup_det.sv
module lfsr_lockup_det #(
   parameter int unsigned  N        = 8,
   parameter logic [N-1:0] MASK     = 8'hB8,
   parameter bit           FLIP_POL = 1'b0
) (
   input  logic [N-1:0] cur_i,
   output logic         hit_o
);

   localparam logic [lfsr_pkg::LFSR_MAX_W-1:0] LOCK_W =
      lfsr_pkg::lockup_word(lfsr_pkg::LFSR_MAX_W'(MASK), N, FLIP_POL);
   localparam logic [N-1:0] LOCK = LOCK_W[N-1:0];

   generate
      if (FLIP_POL) begin : g_cmp_const
         assign hit_o = (cur_i == LOCK);
      end else begin : g_wide_nor
         assign hit_o = ~|cur_i;
      end
   endgenerate

endmodule

// File: rtl/lfsr_inv_reg.sv
module lfsr_inv_reg #(
   parameter int unsigned N        = 8,
   parameter int unsigned SEED_BIT = 0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);

   logic [N-1:0] raw_q;
   logic [N-1:0] raw_d;

   // One flop is kept inverted; every other flop stores its bit as is.
   generate
      for (genvar b = 0; b < N; b++) begin : g_bit
         if (b == SEED_BIT) begin : g_inv
            assign raw_d[b] = ~d_i[b];
            assign q_o[b]   = ~raw_q[b];
         end else begin : g_dir
            assign raw_d[b] = d_i[b];
            assign q_o[b]   = raw_q[b];
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) raw_q <= '0;
      else       raw_q <= raw_d;
   end

endmodule

// File: rtl/galois_lfsr_gen.sv
module galois_lfsr_gen #(
   parameter int unsigned  N        = 8,
   parameter logic [N-1:0] MASK     = 8'hB8,
   parameter bit           FLIP_POL = 1'b0,
   parameter int unsigned  SEED_BIT = 0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   input  logic         ld_i,
   input  logic [N-1:0] ld_val_i,
   output logic [N-1:0] state_o,
   output logic         bit_o,
   output logic         recov_o
);

   localparam logic [N-1:0] SEED = {{(N-1){1'b0}}, 1'b1} << SEED_BIT;
   localparam logic [lfsr_pkg::LFSR_MAX_W-1:0] LOCK_W =
      lfsr_pkg::lockup_word(lfsr_pkg::LFSR_MAX_W'(MASK), N, FLIP_POL);
   localparam logic [lfsr_pkg::LFSR_MAX_W-1:0] LOCK_STEP_W =
      lfsr_pkg::step_word(LOCK_W, lfsr_pkg::LFSR_MAX_W'(MASK), N, FLIP_POL);
   localparam logic [N-1:0] LOCK = LOCK_W[N-1:0];

   // Elaboration-time parameter checks
   generate
      if (N < 2 || N > lfsr_pkg::LFSR_MAX_W) begin : g_bad_width
         $error("galois_lfsr_gen: N out of range");
      end
      if (SEED_BIT >= N) begin : g_bad_seed
         $error("galois_lfsr_gen: SEED_BIT outside the register");
      end
      if (MASK[N-1] != 1'b1) begin : g_bad_mask
         $error("galois_lfsr_gen: top mask bit must be set");
      end
      if (LOCK_STEP_W != LOCK_W) begin : g_no_fixed_point
         $error("galois_lfsr_gen: mask gives no single stuck state");
      end
      if (SEED == LOCK) begin : g_seed_stuck
         $error("galois_lfsr_gen: seed equals the stuck state");
      end
   endgenerate

   logic [N-1:0] cur;
   logic [N-1:0] stepped;
   logic [N-1:0] nxt;
   logic         stuck;
   logic         escape;

   lfsr_step #(.N(N), .MASK(MASK), .FLIP_POL(FLIP_POL)) u_step (
      .cur_i (cur),
      .nxt_o (stepped)
   );

   lfsr_lockup_det #(.N(N), .MASK(MASK), .FLIP_POL(FLIP_POL)) u_det (
      .cur_i (cur),
      .hit_o (stuck)
   );

   lfsr_inv_reg #(.N(N), .SEED_BIT(SEED_BIT)) u_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (nxt),
      .q_o   (cur)
   );

   assign escape = en_i & ~ld_i & stuck;

   always_comb begin
      if (ld_i)        nxt = ld_val_i;
      else if (escape) nxt = SEED;
      else if (en_i)   nxt = stepped;
      else             nxt = cur;
   end

   assign state_o = cur;
   assign bit_o   = cur[0];
   assign recov_o = escape;

   // R1: reset leaves the single-one seed and no flag
   a_r1_reset_seed: assert property (@(posedge clk_i)
      rst_i |=> (state_o == SEED && !recov_o));

   // R8: the escape step lands on the seed
   a_r8_escape_to_seed: assert property (@(posedge clk_i) disable iff (rst_i)
      recov_o |=> (state_o == SEED));

   // R9: the flag never lasts two cycles
   a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
      recov_o |=> !recov_o);

   // R4: idle cycles keep the state
   a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (!en_i && !ld_i) |=> $stable(state_o));

   // R10: a load writes the word
   a_r10_load: assert property (@(posedge clk_i) disable iff (rst_i)
      ld_i |=> (state_o == $past(ld_val_i)));

   // R5: serial bit mirrors the low state bit
   always_comb begin
      a_r5_serial: assert (bit_o === state_o[0] || $isunknown(state_o));
   end

endmodule

// File: tb/tb_galois_lfsr_gen.sv
module tb_galois_lfsr_gen;

   localparam int unsigned N    = 8;
   localparam logic [7:0]  MASK = 8'hB8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic       ld  = 1'b0;
   logic [7:0] ld_val = 8'h00;

   logic [7:0] st_a, st_b;
   logic       bit_a, bit_b, rec_a, rec_b;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   galois_lfsr_gen #(.N(N), .MASK(MASK), .FLIP_POL(1'b0), .SEED_BIT(0)) dut (
      .clk_i(clk), .rst_i(rst), .en_i(en), .ld_i(ld), .ld_val_i(ld_val),
      .state_o(st_a), .bit_o(bit_a), .recov_o(rec_a));

   galois_lfsr_gen #(.N(N), .MASK(MASK), .FLIP_POL(1'b1), .SEED_BIT(3)) dut_inv (
      .clk_i(clk), .rst_i(rst), .en_i(en), .ld_i(ld), .ld_val_i(ld_val),
      .state_o(st_b), .bit_o(bit_b), .recov_o(rec_b));

   localparam logic [7:0] SEED_A = 8'h01;
   localparam logic [7:0] SEED_B = 8'h08;

   function automatic logic [7:0] model_step(input logic [7:0] s, input bit flip);
      logic [7:0] t;
      t = s >> 1;
      if (s[0] ^ flip) t = t ^ MASK;
      return t;
   endfunction

   function automatic logic [7:0] model_lock(input bit flip);
      logic [7:0] x;
      x = 8'h00;
      if (flip) for (int k = 0; k < 7; k++) x[k+1] = x[k] ^ MASK[k];
      return x;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      logic [7:0] lk_a, lk_b, prev_a, prev_b;
      int per_a, per_b, run, max_run;
      lk_a = model_lock(1'b0);
      lk_b = model_lock(1'b1);

      @(negedge clk);
      tick();
      tick();
      rst = 1'b0;
      // R1: reset state
      check(st_a == SEED_A, "R1 seed plain", st_a, SEED_A);
      check(st_b == SEED_B, "R1 seed flipped", st_b, SEED_B);
      check(!rec_a && !rec_b, "R1 flag low", {rec_a, rec_b}, 0);
      // R8: flipped stuck word for 0xB8
      check(lk_b == 8'hD0, "R8 stuck word", lk_b, 8'hD0);

      // R2 R3 R5 R6 R7: two full periods, step by step
      en = 1'b1;
      per_a = 0; per_b = 0; run = 0; max_run = 0;
      for (int i = 1; i <= 510; i++) begin
         prev_a = st_a;
         prev_b = st_b;
         tick();
         check(st_a == model_step(prev_a, 1'b0), "R2 plain step", st_a, model_step(prev_a, 1'b0));
         check(st_b == model_step(prev_b, 1'b1), "R3 flipped step", st_b, model_step(prev_b, 1'b1));
         check(bit_a == st_a[0] && bit_b == st_b[0], "R5 serial bit", {bit_a, bit_b}, {st_a[0], st_b[0]});
         check(!rec_a && !rec_b, "R9 no flag on long cycle", {rec_a, rec_b}, 0);
         if (per_a == 0 && st_a == SEED_A) per_a = i;
         if (per_b == 0 && st_b == SEED_B) per_b = i;
         if (bit_a == 1'b0) run++; else run = 0;
         if (run > max_run) max_run = run;
      end
      check(per_a == 255, "R6 period plain", per_a, 255);
      check(per_b == 255, "R6 period flipped", per_b, 255);
      check(max_run == 7, "R7 longest zero run", max_run, 7);

      // R4: hold with enable low
      en = 1'b0;
      prev_a = st_a;
      prev_b = st_b;
      for (int i = 0; i < 5; i++) begin
         tick();
         check(st_a == prev_a && st_b == prev_b, "R4 hold", st_a, prev_a);
      end

      // R10: load with enable low
      ld = 1'b1; ld_val = 8'hA5;
      tick();
      ld = 1'b0;
      check(st_a == 8'hA5 && st_b == 8'hA5, "R10 load", st_a, 8'hA5);

      // R8 R9: park in stuck state with enable low, then escape
      ld = 1'b1; ld_val = lk_a;
      tick();
      ld = 1'b0;
      check(st_a == lk_a && !rec_a, "R9 no flag while idle", {st_a, rec_a}, {lk_a, 1'b0});
      en = 1'b1;
      #1;
      check(rec_a == 1'b1, "R9 flag on escape", rec_a, 1);
      tick();
      check(st_a == SEED_A, "R8 plain escape", st_a, SEED_A);
      check(rec_a == 1'b0, "R9 flag one cycle", rec_a, 0);
      en = 1'b0;
      ld = 1'b1; ld_val = lk_b;
      tick();
      ld = 1'b0;
      en = 1'b1;
      #1;
      check(rec_b == 1'b1, "R9 flag flipped", rec_b, 1);
      tick();
      check(st_b == SEED_B, "R8 flipped escape", st_b, SEED_B);
      en = 1'b0;

      // R10: load collides with escape
      ld = 1'b1; ld_val = lk_a;
      tick();
      ld_val = 8'h33; en = 1'b1;
      #1;
      check(rec_a == 1'b0, "R10 load masks flag", rec_a, 0);
      tick();
      ld = 1'b0; en = 1'b0;
      check(st_a == 8'h33, "R10 load beats escape", st_a, 8'h33);

      // R11: reset beats load and enable
      rst = 1'b1; ld = 1'b1; en = 1'b1; ld_val = 8'h77;
      tick();
      rst = 1'b0; ld = 1'b0; en = 1'b0;
      check(st_a == SEED_A && st_b == SEED_B, "R11 reset priority", st_a, SEED_A);

      // R2 R3 R8 R9: sweep every starting word
      for (int v = 0; v < 256; v++) begin
         logic [7:0] ea, eb;
         ld = 1'b1; en = 1'b0; ld_val = 8'(v);
         tick();
         ld = 1'b0; en = 1'b1;
         #1;
         check(rec_a == (8'(v) == lk_a), "R9 sweep flag plain", rec_a, (8'(v) == lk_a));
         check(rec_b == (8'(v) == lk_b), "R9 sweep flag flipped", rec_b, (8'(v) == lk_b));
         ea = (8'(v) == lk_a) ? SEED_A : model_step(8'(v), 1'b0);
         eb = (8'(v) == lk_b) ? SEED_B : model_step(8'(v), 1'b1);
         tick();
         en = 1'b0;
         check(st_a == ea, "R2 R8 sweep plain", st_a, ea);
         check(st_b == eb, "R3 R8 sweep flipped", st_b, eb);
      end

      finish_run();
   end

endmodule